// File: doc/BRIEF.md
# Two-Register Addressing-Mode Sequencer

This block is a small instruction sequencer. It holds a program counter, one data register and one address register that the indirect instructions use. Program and data share a single word-addressed memory inside the block. The memory has one registered read port for the sequencer and one write port that the surrounding logic uses to load a program. Loading is done while reset is held, and the sequencer starts fetching at address zero once reset is released.

Instructions are one or two words long, depending on how they address their operand. Immediate and direct forms carry a second word after the opcode. Indirect forms are a single word and take their effective address from the address register. The instruction set has six operations: load the address register with a constant, load the data register from a direct address, load the data register through the address register, jump to a direct address, jump through the address register, and halt. Any other opcode does nothing. A one-cycle strobe marks the cycle in which each instruction retires, so the surrounding logic can follow the program-counter trace.

Top module: `aseq_core`

## Requirements
- R1: A synchronous reset, held for any number of cycles, leaves pc_o, r0_o and iar_o at 0, and halted_o and done_o at 0. Reset also clears a halted sequencer. Execution then starts at address 0.
- R2: The opcode is bits [15:12] of the first word and the lower bits are ignored. The encodings are 0x1 immediate address-register load, 0x2 direct data load, 0x3 indirect data load, 0x4 direct jump, 0x5 indirect jump and 0xF halt. Every other opcode only moves pc_o on by one.
- R3: Opcode 0x1 copies the following word into iar_o and leaves pc_o two words past the opcode.
- R4: Opcode 0x2 loads r0_o with the memory word whose address is the following word. It leaves pc_o two words past the opcode and iar_o unchanged.
- R5: Opcode 0x3 is a single word. It loads r0_o with the memory word at the address in iar_o and leaves pc_o one word past the opcode.
- R6: Opcode 0x4 sets pc_o to the following word and leaves r0_o and iar_o unchanged.
- R7: Opcode 0x5 sets pc_o to the value of iar_o and leaves r0_o unchanged.
- R8: Opcode 0xF raises halted_o, which then stays high until reset. pc_o is left one word past the halt, and pc_o, r0_o and iar_o no longer change.
- R9: done_o is high for exactly one cycle per instruction, and register values change only at the end of that cycle. An instruction takes 3 cycles if it is one word with no data read (no-op, indirect jump, halt). It takes 4 cycles for the immediate load, the direct jump and the indirect load, and 5 cycles for the direct load.
- R10: A read from any address at or above 2**MEM_AW returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Write enable of the program-load port |
| ld_addr | input | MEM_AW | Word address of the load port |
| ld_data | input | DATA_W | Word written by the load port |
| pc_o | output | DATA_W | Program counter |
| r0_o | output | DATA_W | Data register |
| iar_o | output | DATA_W | Indirect address register |
| halted_o | output | 1 | High once a halt has executed |
| done_o | output | 1 | One-cycle strobe in the cycle an instruction retires |

## Verification
The assertions watch, on every cycle, the properties that are independent of any program. The data and address registers move only at a retirement strobe. Two strobes are always at least three cycles apart. Halted is entered only through a retirement, and once halted it stays high with every register frozen. The registers are also checked to be cleared after reset. What each opcode computes, the two-word versus one-word length of each addressing form, the exact cycle count of each form, and the zero result of an out-of-range read can only be shown by the bench's directed programs, which compare the registers and pc against values worked out by hand.

// File: rtl/aseq_pkg.sv
package aseq_pkg;

   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OPC_LDI_IAR = 4'h1;
   localparam logic [OPC_W-1:0] OPC_LD_DIR  = 4'h2;
   localparam logic [OPC_W-1:0] OPC_LD_IND  = 4'h3;
   localparam logic [OPC_W-1:0] OPC_JMP_DIR = 4'h4;
   localparam logic [OPC_W-1:0] OPC_JMP_IND = 4'h5;
   localparam logic [OPC_W-1:0] OPC_HALT    = 4'hF;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_DECODE,
      ST_OPERAND,
      ST_MEMREAD,
      ST_EXECUTE,
      ST_HALTED
   } aseq_state_e;

   typedef struct packed {
      logic has_opnd;
      logic mem_rd;
      logic wr_iar;
      logic wr_r0;
      logic jmp_dir;
      logic jmp_ind;
      logic halt;
   } aseq_dec_t;

endpackage

// File: rtl/aseq_mem.sv
module aseq_mem #(
   parameter int DW = 16,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 2 ** AW;

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   generate
      if (AW < DW) begin : g_guarded
         logic above;
         assign above = |rd_addr[DW-1:AW];
         always_ff @(posedge clk) begin
            rd_data <= above ? '0 : store[rd_addr[AW-1:0]];
         end
      end else begin : g_full
         always_ff @(posedge clk) begin
            rd_data <= store[rd_addr];
         end
      end
   endgenerate

endmodule

// File: rtl/aseq_decode.sv
module aseq_decode
   import aseq_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output aseq_dec_t        dec
);
   always_comb begin
      dec = '0;
      case (opc)
         OPC_LDI_IAR: begin dec.has_opnd = 1'b1; dec.wr_iar = 1'b1; end
         OPC_LD_DIR:  begin dec.has_opnd = 1'b1; dec.mem_rd = 1'b1; dec.wr_r0 = 1'b1; end
         OPC_LD_IND:  begin dec.mem_rd = 1'b1; dec.wr_r0 = 1'b1; end
         OPC_JMP_DIR: begin dec.has_opnd = 1'b1; dec.jmp_dir = 1'b1; end
         OPC_JMP_IND: dec.jmp_ind = 1'b1;
         OPC_HALT:    dec.halt = 1'b1;
         default:     dec = '0;
      endcase
   end
endmodule

// File: rtl/aseq_ctrl.sv
module aseq_ctrl
   import aseq_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DW-1:0]    rd_data,
   input  aseq_dec_t        dec,
   output logic [OPC_W-1:0] opc,
   output logic [DW-1:0]    rd_addr,
   output logic [DW-1:0]    pc,
   output logic [DW-1:0]    r0,
   output logic [DW-1:0]    iar,
   output logic             halted,
   output logic             done
);
   localparam logic [DW-1:0] STEP = DW'(1);

   aseq_state_e      state;
   logic [OPC_W-1:0] ir;
   logic [DW-1:0]    opnd;
   logic [DW-1:0]    mdata;

   assign opc    = (state == ST_DECODE) ? rd_data[DW-1 -: OPC_W] : ir;
   assign halted = (state == ST_HALTED);
   assign done   = (state == ST_EXECUTE);

   always_comb begin
      case (state)
         ST_DECODE:  rd_addr = dec.has_opnd ? pc : iar;
         ST_OPERAND: rd_addr = rd_data;
         default:    rd_addr = pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_FETCH;
         pc    <= '0;
         r0    <= '0;
         iar   <= '0;
         ir    <= '0;
         opnd  <= '0;
         mdata <= '0;
      end else begin
         case (state)
            ST_FETCH: begin
               pc    <= pc + STEP;
               state <= ST_DECODE;
            end
            ST_DECODE: begin
               ir <= rd_data[DW-1 -: OPC_W];
               if (dec.has_opnd) begin
                  pc    <= pc + STEP;
                  state <= ST_OPERAND;
               end else if (dec.mem_rd) begin
                  state <= ST_MEMREAD;
               end else begin
                  state <= ST_EXECUTE;
               end
            end
            ST_OPERAND: begin
               opnd  <= rd_data;
               state <= dec.mem_rd ? ST_MEMREAD : ST_EXECUTE;
            end
            ST_MEMREAD: begin
               mdata <= rd_data;
               state <= ST_EXECUTE;
            end
            ST_EXECUTE: begin
               if (dec.wr_iar)  iar <= opnd;
               if (dec.wr_r0)   r0  <= mdata;
               if (dec.jmp_dir) pc  <= opnd;
               if (dec.jmp_ind) pc  <= iar;
               state <= dec.halt ? ST_HALTED : ST_FETCH;
            end
            default: state <= ST_HALTED;
         endcase
      end
   end

endmodule

// File: rtl/aseq_core.sv
module aseq_core
   import aseq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int MEM_AW = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ld_en,
   input  logic [MEM_AW-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] pc_o,
   output logic [DATA_W-1:0] r0_o,
   output logic [DATA_W-1:0] iar_o,
   output logic              halted_o,
   output logic              done_o
);
   generate
      if (DATA_W <= OPC_W) begin : g_bad_width
         $error("aseq_core: DATA_W must exceed the opcode width");
      end
      if (MEM_AW < 1 || MEM_AW > DATA_W || MEM_AW > 12) begin : g_bad_depth
         $error("aseq_core: MEM_AW must lie in 1..min(DATA_W,12)");
      end
   endgenerate

   logic [DATA_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic [OPC_W-1:0]  opc;
   aseq_dec_t         dec;

   aseq_mem #(.DW(DATA_W), .AW(MEM_AW)) u_mem (
      .clk     (clk),
      .wr_en   (ld_en),
      .wr_addr (ld_addr),
      .wr_data (ld_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   aseq_decode u_dec (
      .opc (opc),
      .dec (dec)
   );

   aseq_ctrl #(.DW(DATA_W)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .rd_data (rd_data),
      .dec     (dec),
      .opc     (opc),
      .rd_addr (rd_addr),
      .pc      (pc_o),
      .r0      (r0_o),
      .iar     (iar_o),
      .halted  (halted_o),
      .done    (done_o)
   );

endmodule

// File: rtl/aseq_core_chk.sv
module aseq_core_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic [DW-1:0] pc_o,
   input logic [DW-1:0] r0_o,
   input logic [DW-1:0] iar_o,
   input logic          halted_o,
   input logic          done_o
);
   logic rst_q = 1'b0;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst_q) begin
         p_reset_clear_r1: assert (pc_o == '0 && r0_o == '0 && iar_o == '0
                                   && !halted_o && !done_o)
            else $error("registers not cleared after reset");
      end
   end

   p_halt_frozen_r8: assert property (@(posedge clk) disable iff (rst)
      halted_o |=> halted_o && $stable(pc_o) && $stable(r0_o) && $stable(iar_o));

   p_halt_via_retire_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(halted_o) |-> $past(done_o));

   p_regs_at_retire_r9: assert property (@(posedge clk) disable iff (rst)
      !done_o |=> $stable(r0_o) && $stable(iar_o));

   p_strobe_gap_r9: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o ##1 !done_o);

   p_no_strobe_halted_r9: assert property (@(posedge clk) disable iff (rst)
      halted_o |-> !done_o);

endmodule

bind aseq_core aseq_core_chk #(.DW(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pc_o     (pc_o),
   .r0_o     (r0_o),
   .iar_o    (iar_o),
   .halted_o (halted_o),
   .done_o   (done_o)
);

// File: tb/aseq_core_test.sv
module aseq_core_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ld_en = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;
   logic [DW-1:0] pc_o, r0_o, iar_o;
   logic          halted_o, done_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aseq_core #(.DATA_W(DW), .MEM_AW(AW)) uut (
      .clk (clk), .rst (rst), .ld_en (ld_en), .ld_addr (ld_addr),
      .ld_data (ld_data), .pc_o (pc_o), .r0_o (r0_o), .iar_o (iar_o),
      .halted_o (halted_o), .done_o (done_o)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // Runs one instruction from a negedge in FETCH; returns its cycle count and
   // leaves the bench at the negedge after retirement, with results visible.
   task automatic step(output int n);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         n++;
         if (done_o) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 pc", pc_o, 16'h0);
      chk("R1 r0", r0_o, 16'h0);
      chk("R1 iar", iar_o, 16'h0);
      chk("R1 halted", {15'b0, halted_o}, 16'h0);
      chk("R1 done", {15'b0, done_o}, 16'h0);
   endtask

   task automatic t_load_program;
      load_word(6'h00, 16'h1000); load_word(6'h01, 16'h0030);
      load_word(6'h02, 16'h3ABC);
      load_word(6'h03, 16'h4555); load_word(6'h04, 16'h0010);
      load_word(6'h10, 16'h2000); load_word(6'h11, 16'h0031);
      load_word(6'h12, 16'h2000); load_word(6'h13, 16'h8000);
      load_word(6'h14, 16'h7123);
      load_word(6'h15, 16'h1000); load_word(6'h16, 16'h0020);
      load_word(6'h17, 16'h5000);
      load_word(6'h20, 16'hF000);
      load_word(6'h30, 16'h01AC); load_word(6'h31, 16'hBEEF);
   endtask

   task automatic t_program_trace;
      int n;
      rst = 1'b0;
      step(n);   // LDI IAR 0x30
      chk("R3 iar", iar_o, 16'h0030); chk("R3 pc", pc_o, 16'h0002);
      chk("R9 ldi cycles", 16'(n), 16'd4);
      step(n);   // indirect load, low opcode bits nonzero (R2)
      chk("R5 r0", r0_o, 16'h01AC); chk("R5 pc", pc_o, 16'h0003);
      chk("R2 low bits ignored iar", iar_o, 16'h0030);
      chk("R9 ind load cycles", 16'(n), 16'd4);
      step(n);   // direct jump to 0x10
      chk("R6 pc", pc_o, 16'h0010); chk("R6 r0", r0_o, 16'h01AC);
      chk("R6 iar", iar_o, 16'h0030);
      chk("R9 jmp cycles", 16'(n), 16'd4);
      step(n);   // direct load from 0x31
      chk("R4 r0", r0_o, 16'hBEEF); chk("R4 pc", pc_o, 16'h0012);
      chk("R4 iar", iar_o, 16'h0030);
      chk("R9 dir load cycles", 16'(n), 16'd5);
      step(n);   // direct load from 0x8000, outside memory
      chk("R10 r0", r0_o, 16'h0000); chk("R10 pc", pc_o, 16'h0014);
      step(n);   // unknown opcode 0x7
      chk("R2 nop pc", pc_o, 16'h0015); chk("R2 nop r0", r0_o, 16'h0000);
      chk("R2 nop iar", iar_o, 16'h0030);
      chk("R9 nop cycles", 16'(n), 16'd3);
      step(n);   // LDI IAR 0x20
      chk("R3 iar second", iar_o, 16'h0020); chk("R3 pc second", pc_o, 16'h0017);
      step(n);   // indirect jump
      chk("R7 pc", pc_o, 16'h0020); chk("R7 r0", r0_o, 16'h0000);
      chk("R9 jmpi cycles", 16'(n), 16'd3);
      step(n);   // halt
      chk("R8 halted", {15'b0, halted_o}, 16'h1); chk("R8 pc", pc_o, 16'h0021);
      chk("R9 halt cycles", 16'(n), 16'd3);
   endtask

   task automatic t_halt_hold;
      int strobes = 0;
      int drops = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (done_o) strobes++;
         if (!halted_o || pc_o !== 16'h0021 || iar_o !== 16'h0020) drops++;
      end
      chk("R8 stays halted", 16'(drops), 16'd0);
      chk("R9 no strobe while halted", 16'(strobes), 16'd0);
   endtask

   task automatic t_restart;
      int n;
      t_reset();
      rst = 1'b0;
      step(n);
      chk("R1 restart iar", iar_o, 16'h0030);
      chk("R1 restart pc", pc_o, 16'h0002);
      chk("R1 restart halted", {15'b0, halted_o}, 16'h0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_load_program();
      t_reset();
      t_program_trace();
      t_halt_hold();
      t_restart();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule